// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit logical address into a physical address by walking a two-level translation table that lives in a word-addressed memory. A requester presents an address and an access kind (read, write or execute) with a single-cycle `req`. The walker then runs through its steps without further input. First it reads the entry in the root table, which sits at a fixed word address and never moves. Then it reads the entry in the second-level table that the root entry points to. It checks the present and permission bits, writes the referenced and modified flags back into the final entry, and returns the physical address.

When a check fails, the block returns a fault status instead of a translation and keeps the faulting logical address in a register. There are two fault kinds: the page is absent at either level, or the access kind is not permitted. The block serves one request at a time. It holds `busy` high for the whole walk and pulses `done` once at the end.

Memory timing: the memory read port has a latency of one cycle. Data for a read issued in one cycle is presented on `mem_rdata` in the next cycle.

Top module: `pt_walker`

## Requirements
- R1: A logical address is split into index A (bits 31:22), index B (bits 21:12) and offset (bits 11:0). On success, `pa` equals the final entry's frame field (entry bits 31:12) followed by the unchanged offset, and `status` is 0.
- R2: The first memory read goes to word address `ROOT_BASE + indexA`. If that entry is present, the second read goes to word address `(frame << 10) | indexB`, where the frame is bits 31:12 of the root entry. No other reads happen during a walk. Read and write strobes are never active together.
- R3: A root entry whose bit 0 (present) is clear ends the walk with `status` = 1 (page absent) and `pa` = 0. No second-level read is issued.
- R4: A present root entry that leads to a second-level entry with bit 0 clear ends the walk with `status` = 1 and `pa` = 0.
- R5: Access kind 0 (read) needs bit 5 of the final entry, kind 1 (write) needs bit 4, and kind 2 (execute) needs bit 3. Kind 3 is always refused. A refused access ends the walk with `status` = 2 and `pa` = 0. Permission bits in the root entry have no effect.
- R6: On success, exactly one write goes to the address of the second-level entry. The written word is the entry as read with bit 1 (referenced) set, and with bit 2 (modified) also set on a write access; all other bits are unchanged. A faulting walk writes nothing.
- R7: On every fault, `fault_addr` takes the logical address of the faulting request. It keeps that value through successful walks until the next fault.
- R8: `busy` rises on the edge that accepts `req` and stays high until the end of the walk. A `req` that arrives while `busy` is high is ignored.
- R9: `done` is high for exactly one cycle. It rises 2 edges after the accepting edge for a root-level absence, 4 edges after for a second-level fault, and 5 edges after for a success. `busy` falls on the following edge.
- R10: After reset, `busy`, `done`, `status`, `pa`, `fault_addr` and both memory strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Start a walk (taken only while idle) |
| va | input | ADDR_W | Logical address of the request |
| acc | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion strobe |
| status | output | 2 | 0 ok, 1 page absent, 2 access refused |
| pa | output | 32 | Physical address (0 after a fault) |
| fault_addr | output | ADDR_W | Logical address of the latest fault |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | MEM_AW | Memory word address |
| mem_wdata | output | 32 | Write-back data |
| mem_rdata | input | 32 | Read data, one cycle after `mem_re` |

## Verification
The bench builds the walker with its default parameters: 10-bit indices, a 12-bit offset, 32-bit memory addresses and the root table at word 0x400. With these values the second-level tables sit at frame 0x10 and above, clear of the root table. So the memory model can tell the read order and the write-back target apart by address alone. Eight root slots are filled, one of them deliberately absent. Each filled slot leads to a table with three present entries and one absent entry. Together these reach every fault path, every access kind, and repeated write-backs to the same entry.

// File: rtl/pt_pkg.sv
package pt_pkg;
  localparam int DW = 32;

  // entry bit positions
  localparam int B_PRES = 0;
  localparam int B_REF  = 1;
  localparam int B_MOD  = 2;
  localparam int B_X    = 3;
  localparam int B_W    = 4;
  localparam int B_R    = 5;

  localparam logic [1:0] ACC_RD = 2'd0;
  localparam logic [1:0] ACC_WR = 2'd1;
  localparam logic [1:0] ACC_EX = 2'd2;

  typedef enum logic [2:0] {
    S_IDLE, S_L1RD, S_L1CK, S_L2RD, S_L2CK, S_WB, S_FIN
  } walk_state_t;

  typedef enum logic [1:0] {
    ST_OK   = 2'd0,
    ST_PAGE = 2'd1,
    ST_PROT = 2'd2
  } walk_status_t;

  // rwx = {read, write, execute} permission bits of an entry
  function automatic logic perm_ok(logic [2:0] rwx, logic [1:0] acc);
    case (acc)
      ACC_RD:  return rwx[2];
      ACC_WR:  return rwx[1];
      ACC_EX:  return rwx[0];
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [DW-1:0] ent_touch(logic [DW-1:0] e, logic [1:0] acc);
    logic [DW-1:0] t;
    t = e;
    t[B_REF] = 1'b1;
    if (acc == ACC_WR) t[B_MOD] = 1'b1;
    return t;
  endfunction
endpackage

// File: rtl/pt_entry_check.sv
module pt_entry_check
  import pt_pkg::*;
(
  input  logic [DW-1:0] rdata,
  input  logic [1:0]    acc,
  output logic          present,
  output logic          allowed,
  output logic [DW-1:0] touched
);
  assign present = rdata[B_PRES];
  assign allowed = perm_ok(rdata[B_R:B_X], acc);
  assign touched = ent_touch(rdata, acc);
endmodule

// File: rtl/pt_addr_gen.sv
module pt_addr_gen #(
  parameter int          ADDR_W    = 32,
  parameter int          L1_W      = 10,
  parameter int          L2_W      = 10,
  parameter int          OFF_W     = 12,
  parameter int          MEM_AW    = 32,
  parameter logic [31:0] ROOT_BASE = 32'h0000_0400
) (
  input  logic [ADDR_W-1:0]            va,
  input  logic [pt_pkg::DW-OFF_W-1:0]  frame1,
  input  logic [pt_pkg::DW-OFF_W-1:0]  frame2,
  input  logic                         sel_l2,
  output logic [MEM_AW-1:0]            mem_addr,
  output logic [pt_pkg::DW-1:0]        pa_next
);
  localparam int FRAME_W = pt_pkg::DW - OFF_W;

  logic [L1_W-1:0]   idx1;
  logic [L2_W-1:0]   idx2;
  logic [OFF_W-1:0]  off;
  logic [MEM_AW-1:0] l1_addr;
  logic [MEM_AW-1:0] l2_addr;

  assign idx1 = va[ADDR_W-1 -: L1_W];
  assign idx2 = va[OFF_W +: L2_W];
  assign off  = va[OFF_W-1:0];

  assign l1_addr = MEM_AW'(ROOT_BASE) + MEM_AW'(idx1);
  assign l2_addr = MEM_AW'({frame1, idx2});

  assign mem_addr = sel_l2 ? l2_addr : l1_addr;
  assign pa_next  = {frame2, off};

  logic [FRAME_W-1:0] unused_w;
  assign unused_w = '0;
endmodule

// File: rtl/pt_walk_fsm.sv
module pt_walk_fsm
  import pt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic present,
  input  logic allowed,
  output logic busy,
  output logic done,
  output logic mem_re,
  output logic mem_we,
  output logic sel_l2,
  output logic accept,
  output logic l1_pass,
  output logic l2_pass,
  output logic pg_fault,
  output logic prot_fault
);
  walk_state_t st_q, st_d;

  assign accept     = (st_q == S_IDLE) && req;
  assign l1_pass    = (st_q == S_L1CK) && present;
  assign l2_pass    = (st_q == S_L2CK) && present && allowed;
  assign pg_fault   = ((st_q == S_L1CK) || (st_q == S_L2CK)) && !present;
  assign prot_fault = (st_q == S_L2CK) && present && !allowed;

  assign busy   = (st_q != S_IDLE);
  assign done   = (st_q == S_FIN);
  assign mem_re = (st_q == S_L1RD) || (st_q == S_L2RD);
  assign mem_we = (st_q == S_WB);
  assign sel_l2 = (st_q == S_L2RD) || (st_q == S_L2CK) || (st_q == S_WB);

  always_comb begin
    st_d = st_q;
    case (st_q)
      S_IDLE: if (req) st_d = S_L1RD;
      S_L1RD: st_d = S_L1CK;
      S_L1CK: st_d = present ? S_L2RD : S_FIN;
      S_L2RD: st_d = S_L2CK;
      S_L2CK: st_d = (present && allowed) ? S_WB : S_FIN;
      S_WB:   st_d = S_FIN;
      S_FIN:  st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= S_IDLE;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter int          L1_W      = 10,
  parameter int          L2_W      = 10,
  parameter int          OFF_W     = 12,
  parameter int          MEM_AW    = 32,
  parameter logic [31:0] ROOT_BASE = 32'h0000_0400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [ADDR_W-1:0] va,
  input  logic [1:0]        acc,
  output logic              busy,
  output logic              done,
  output logic [1:0]        status,
  output logic [DW-1:0]     pa,
  output logic [ADDR_W-1:0] fault_addr,
  output logic              mem_re,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic [DW-1:0]     mem_rdata
);
  localparam int FRAME_W = DW - OFF_W;

  logic              accept, l1_pass, l2_pass, pg_fault, prot_fault, sel_l2;
  logic              present, allowed;
  logic [DW-1:0]     touched, pa_next;
  logic [ADDR_W-1:0] va_q;
  logic [1:0]        acc_q;
  logic [FRAME_W-1:0] frame1_q;
  logic [DW-1:0]     entry_q;
  walk_status_t      status_q;
  logic [DW-1:0]     pa_q;
  logic [ADDR_W-1:0] fault_addr_q;

  pt_walk_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .req(req),
    .present(present), .allowed(allowed),
    .busy(busy), .done(done), .mem_re(mem_re), .mem_we(mem_we),
    .sel_l2(sel_l2), .accept(accept), .l1_pass(l1_pass),
    .l2_pass(l2_pass), .pg_fault(pg_fault), .prot_fault(prot_fault)
  );

  pt_entry_check u_chk_ent (
    .rdata(mem_rdata), .acc(acc_q),
    .present(present), .allowed(allowed), .touched(touched)
  );

  pt_addr_gen #(
    .ADDR_W(ADDR_W), .L1_W(L1_W), .L2_W(L2_W), .OFF_W(OFF_W),
    .MEM_AW(MEM_AW), .ROOT_BASE(ROOT_BASE)
  ) u_addr (
    .va(va_q), .frame1(frame1_q), .frame2(mem_rdata[DW-1:OFF_W]),
    .sel_l2(sel_l2), .mem_addr(mem_addr), .pa_next(pa_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va_q         <= '0;
      acc_q        <= '0;
      frame1_q     <= '0;
      entry_q      <= '0;
      status_q     <= ST_OK;
      pa_q         <= '0;
      fault_addr_q <= '0;
    end else begin
      if (accept) begin
        va_q  <= va;
        acc_q <= acc;
      end
      if (l1_pass) frame1_q <= mem_rdata[DW-1:OFF_W];
      if (l2_pass) begin
        entry_q  <= touched;
        pa_q     <= pa_next;
        status_q <= ST_OK;
      end
      if (pg_fault || prot_fault) begin
        status_q     <= pg_fault ? ST_PAGE : ST_PROT;
        pa_q         <= '0;
        fault_addr_q <= va_q;
      end
    end
  end

  assign status     = status_q;
  assign pa         = pa_q;
  assign fault_addr = fault_addr_q;
  assign mem_wdata  = entry_q;
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12,
  parameter int MEM_AW = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req,
  input logic              busy,
  input logic              done,
  input logic [1:0]        status,
  input logic [31:0]       pa,
  input logic [ADDR_W-1:0] fault_addr,
  input logic              mem_re,
  input logic              mem_we,
  input logic [MEM_AW-1:0] mem_addr,
  input logic [1:0]        wb_bits,
  input logic [ADDR_W-1:0] va_q,
  input logic [1:0]        acc_q
);
  assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_re && mem_we));

  assert_wb_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ($past(mem_re, 2) && mem_addr == $past(mem_addr, 2)));

  assert_wb_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (wb_bits[0] && (acc_q != 2'd1 || wb_bits[1])));

  assert_done_in_walk_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  assert_accept_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !busy) |=> busy);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_offset_kept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status == 2'd0) |-> pa[OFF_W-1:0] == va_q[OFF_W-1:0]);

  assert_fault_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status != 2'd0) |-> fault_addr == va_q);

  assert_fault_pa_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status != 2'd0) |-> pa == '0);
endmodule

bind pt_walker pt_walker_chk #(
  .ADDR_W(ADDR_W), .OFF_W(OFF_W), .MEM_AW(MEM_AW)
) u_walker_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .busy(busy), .done(done),
  .status(status), .pa(pa), .fault_addr(fault_addr),
  .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr),
  .wb_bits(mem_wdata[2:1]), .va_q(va_q), .acc_q(acc_q)
);

// File: tb/tb_pt_walker.sv
module tb_pt_walker;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] ROOT = 32'h0000_0400;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [31:0] va = '0;
  logic [1:0]  acc = '0;
  logic        busy, done, mem_re, mem_we;
  logic [1:0]  status;
  logic [31:0] pa, fault_addr, mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  logic [31:0] mem [bit [31:0]];
  logic [31:0] rd_log[$];
  logic [31:0] wa_log[$];
  logic [31:0] wd_log[$];
  logic [31:0] exp_fault_addr = '0;
  logic [9:0]  idx1s [8];
  logic [9:0]  idx2s [4];

  pt_walker #(.ROOT_BASE(ROOT)) dut (
    .clk(clk), .rst_n(rst_n), .req(req), .va(va), .acc(acc),
    .busy(busy), .done(done), .status(status), .pa(pa),
    .fault_addr(fault_addr), .mem_re(mem_re), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] rdm(logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    if (mem_re) begin
      rd_log.push_back(mem_addr);
      mem_rdata <= rdm(mem_addr);
    end
    if (mem_we) begin
      wa_log.push_back(mem_addr);
      wd_log.push_back(mem_wdata);
      mem[mem_addr] = mem_wdata;
    end
  end

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // independent walk model
  task automatic model(input logic [31:0] v, input logic [1:0] k,
                       output logic [1:0] st, output logic [31:0] p, output int lat,
                       output int nrd, output logic [31:0] a1, output logic [31:0] a2,
                       output logic [31:0] wd, output string tag);
    logic [31:0] e1, e2;
    bit perm;
    a1 = ROOT + {22'd0, v[31:22]};
    e1 = rdm(a1);
    a2 = ({12'd0, e1[31:12]} << 10) | {22'd0, v[21:12]};
    p = 0; wd = 0; nrd = 1;
    if (!e1[0]) begin st = 1; lat = 2; tag = "R3"; return; end
    nrd = 2;
    e2 = rdm(a2);
    if (!e2[0]) begin st = 1; lat = 4; tag = "R4"; return; end
    case (k)
      2'd0: perm = e2[5];
      2'd1: perm = e2[4];
      2'd2: perm = e2[3];
      default: perm = 0;
    endcase
    if (!perm) begin st = 2; lat = 4; tag = "R5"; return; end
    st = 0; lat = 5; tag = "R1";
    p = {e2[31:12], v[11:0]};
    wd = e2 | 32'h2 | ((k == 2'd1) ? 32'h4 : 32'h0);
  endtask

  task automatic walk(input logic [31:0] v, input logic [1:0] k, input bit poke);
    logic [1:0] est; logic [31:0] ep, a1, a2, wd; int lat, nrd, cnt; string tag;
    model(v, k, est, ep, lat, nrd, a1, a2, wd, tag);
    rd_log.delete(); wa_log.delete(); wd_log.delete();
    @(negedge clk);
    req = 1; va = v; acc = k;
    cnt = 0;
    do begin
      @(negedge clk);
      cnt++;
      if (cnt == 1) req = 0;
      if (poke && cnt == 2) begin req = 1; va = v ^ 32'hFFC0_0000; acc = 2'd1; end
      if (poke && cnt == 3) req = 0;
    end while (!done && cnt < 40);
    chk(done, "R9 done seen", {31'd0, done}, 32'd1);
    chk(cnt == lat + 1, "R9 latency", cnt, lat + 1);
    chk(status == est, tag, {30'd0, status}, {30'd0, est});
    chk(pa == ep, (est == 0) ? "R1 pa" : "R3 pa zero on fault", pa, ep);
    if (est != 0) exp_fault_addr = v;
    chk(fault_addr == exp_fault_addr, "R7 fault_addr", fault_addr, exp_fault_addr);
    chk(rd_log.size() == nrd, poke ? "R8 reads with ignored req" : "R2 read count",
        rd_log.size(), nrd);
    if (rd_log.size() >= 1) chk(rd_log[0] == a1, "R2 root address", rd_log[0], a1);
    if (nrd == 2 && rd_log.size() >= 2) chk(rd_log[1] == a2, "R2 table address", rd_log[1], a2);
    if (est == 0) begin
      chk(wa_log.size() == 1, "R6 one write", wa_log.size(), 1);
      if (wa_log.size() == 1) begin
        chk(wa_log[0] == a2, "R6 write address", wa_log[0], a2);
        chk(wd_log[0] == wd, "R6 write data", wd_log[0], wd);
      end
    end else
      chk(wa_log.size() == 0, "R6 no write on fault", wa_log.size(), 0);
    @(negedge clk);
    chk(!done && !busy, "R9 pulse ends", {30'd0, done, busy}, 32'd0);
    if (poke) begin
      repeat (3) @(negedge clk);
      chk(!busy, "R8 ignored req started nothing", {31'd0, busy}, 32'd0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 8; i++) idx1s[i] = 10'((i * 131 + 5) & 1023);
    for (int j = 0; j < 4; j++) idx2s[j] = 10'((j * 37 + 2) & 1023);
    for (int i = 0; i < 8; i++) begin
      logic [31:0] base;
      base = (32'(16 + i)) << 10;
      if (i != 7) mem[ROOT + 32'(idx1s[i])] = ((32'(16 + i)) << 12) | ($urandom & 32'h0000_0FFE) | 32'h1;
      for (int j = 0; j < 4; j++)
        mem[base + 32'(idx2s[j])] = ($urandom & 32'hFFFF_FFF8) | ((j < 3) ? 32'h1 : 32'h0);
    end
    // directed entries in table 0
    mem[(32'd16 << 10) + 32'(idx2s[0])] = 32'hABCDE021; // read only
    mem[(32'd16 << 10) + 32'(idx2s[1])] = 32'h12345011; // write only
    mem[(32'd16 << 10) + 32'(idx2s[2])] = 32'h0F00F009; // execute only
    // root entry with all permission bits clear must not block (R5)
    mem[ROOT + 32'(idx1s[1])] = (32'd17 << 12) | 32'h1;

    repeat (2) @(negedge clk);
    // R10 reset state
    chk(!busy && !done && !mem_re && !mem_we, "R10 strobes", {28'd0, busy, done, mem_re, mem_we}, 0);
    chk(status == 0 && pa == 0, "R10 status/pa", pa, 0);
    chk(fault_addr == 0, "R10 fault_addr", fault_addr, 0);
    rst_n = 1;

    walk({idx1s[0], idx2s[0], 12'h5A5}, 2'd0, 0); // R1 read ok
    walk({idx1s[0], idx2s[0], 12'h001}, 2'd1, 0); // R5 write refused
    walk({idx1s[0], idx2s[0], 12'h002}, 2'd2, 0); // R5 exec refused
    walk({idx1s[0], idx2s[0], 12'h003}, 2'd3, 0); // R5 kind 3
    walk({idx1s[0], idx2s[1], 12'hFFF}, 2'd1, 0); // R6 write sets modified
    walk({idx1s[0], idx2s[1], 12'h000}, 2'd0, 0); // R5 read refused
    walk({idx1s[0], idx2s[2], 12'h123}, 2'd2, 0); // R1 exec ok
    walk({idx1s[0], idx2s[3], 12'h456}, 2'd0, 0); // R4 table absent
    walk({idx1s[7], idx2s[0], 12'h789}, 2'd0, 0); // R3 root absent
    walk({idx1s[1], idx2s[0], 12'h0AB}, 2'd0, 1); // R8 ignored req + R5 root perms
    walk({idx1s[1], idx2s[0], 12'h0AC}, 2'd1, 0);

    for (int n = 0; n < 150; n++) begin
      logic [31:0] v;
      v = {idx1s[$urandom_range(7)], idx2s[$urandom_range(3)], 12'($urandom)};
      walk(v, 2'($urandom_range(3)), ($urandom_range(9) == 0));
    end
    summary();
  end
endmodule